// File: doc/BRIEF.md
# SD Host Status and Interrupt Controller

This block holds three software-visible registers of an SD host controller: the host status word, the host configuration word and the debug/state word. It drives one level-sensitive interrupt line from them. The command and data engines live outside the block. They report conditions through a vector of status-set strobes and a single transfer-complete pulse. The complete pulse carries two qualifiers taken from the current command: whether it waits on card busy, and whether it is a write.

Software reaches the three registers over a simple synchronous register port. A write takes effect at the clock edge. Read data is combinational from the address. Status bits are cleared by writing ones. When a transfer completes, the configuration enables decide which interrupt-class status bits are raised, and the debug word's state field moves to the data-mode code. Writing the power-down state code to the debug word is absorbed as the idle code.

Top module: `sdh_status_irq`

## Requirements
- R1: After reset, status reads 0x000, configuration reads 0x000, the debug word reads 0x0000C60F, and the interrupt output is low.
- R2: A write to the status register (offset 0x00) clears, at the next edge, every status bit whose written data bit is one, and leaves the other bits unchanged.
- R3: The interrupt output is high exactly while any of status bits 10 (busy), 9 (block) or 8 (data) is set, and it follows a change of those bits without an extra cycle of delay.
- R4: A transfer-complete pulse always sets status bit 0 (data flag), and it sets status bit 8 only when configuration bit 4 is one.
- R5: A transfer-complete pulse sets status bit 10 only when both the busy-wait qualifier and configuration bit 10 are one.
- R6: A transfer-complete pulse sets status bit 9 only when both the write qualifier and configuration bit 8 are one.
- R7: A transfer-complete pulse sets the debug state field (bits 3:0) to 1 and leaves the other debug bits unchanged. If a debug write arrives in the same cycle, the written value is stored but its state field becomes 1.
- R8: A write to the debug register (offset 0x08) whose bits 3:0 equal 0xF stores 0 in the state field. Any other state value is stored as written.
- R9: The debug word stores bits 21:0 of a write. The write threshold is at bits 13:9 and the read threshold at bits 18:14, and bits 31:22 read as zero.
- R10: When an engine set strobe or a transfer-complete pulse sets a status bit in the same cycle that a software write clears that bit, the bit ends up set.
- R11: Reads of any offset other than 0x00, 0x04 and 0x08 return zero, and writes to such offsets change no register.
- R12: Each bit of the engine set-strobe vector sets the status bit at the same position at the next edge, for all eleven positions.
- R13: The configuration register (offset 0x04) stores bits 10:0 of a write, and bits 31:11 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (6) | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | DATA_W (32) | Register write data |
| busRdData | output | DATA_W (32) | Combinational read data for busAddr |
| evtSet | input | 11 | Status set strobes from the command and data engines |
| xferDone | input | 1 | Transfer-complete pulse |
| cmdBusyWait | input | 1 | Current command waits on card busy |
| cmdIsWrite | input | 1 | Current command is a write |
| irqOut | output | 1 | Level-sensitive interrupt request |

## Verification
A wrong status bit shows up on the read port in the cycle right after the edge that stored it. If the bit is one of bits 10 to 8, it also shows on the interrupt line, because that line is decoded combinationally from the stored word. A wrong gate between a completion and the configuration enables shows one edge after the complete pulse, as a missing or extra interrupt-class bit. A mishandled debug state code shows on the first read after the write or completion that produced it. The races between set and clear, and between completion and a debug write, are driven in single cycles, so a wrong priority shows on the very next read.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;

  localparam int STAT_W  = 11;
  localparam int CFG_W   = 11;
  localparam int DBG_W   = 22;
  localparam int STATE_W = 4;

  // status bit positions
  localparam int ST_DATA_FLAG = 0;
  localparam int ST_DATA_IRQ  = 8;
  localparam int ST_BLOCK_IRQ = 9;
  localparam int ST_BUSY_IRQ  = 10;

  // configuration enable positions
  localparam int CF_DATA_EN  = 4;
  localparam int CF_BLOCK_EN = 8;
  localparam int CF_BUSY_EN  = 10;

  localparam logic [STATE_W-1:0] STATE_IDLE    = 4'h0;
  localparam logic [STATE_W-1:0] STATE_DATA    = 4'h1;
  localparam logic [STATE_W-1:0] STATE_PWRDOWN = 4'hF;

  localparam logic [DBG_W-1:0] DBG_RESET = 22'h00C60F;

  localparam int unsigned OFS_STATUS = 32'h00;
  localparam int unsigned OFS_CONFIG = 32'h04;
  localparam int unsigned OFS_DEBUG  = 32'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_CFG,
    SEL_DBG
  } rdSel_e;

  typedef struct packed {
    logic              wrStat;
    logic              wrCfg;
    logic              wrDbg;
    logic              enterData;
    logic [STAT_W-1:0] setMask;
    rdSel_e            rdSel;
  } strobes_t;

endpackage

// File: rtl/sdh_stat_ctrl.sv
module sdh_stat_ctrl
  import sdh_stat_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [STAT_W-1:0] evtSet,
  input  logic              xferDone,
  input  logic              cmdBusyWait,
  input  logic              cmdIsWrite,
  input  logic [CFG_W-1:0]  cfgQ,
  output strobes_t          strb
);

  localparam int NREG = 3;
  localparam int unsigned REG_OFS [NREG] = '{OFS_STATUS, OFS_CONFIG, OFS_DEBUG};

  logic [NREG-1:0]   regHit;
  logic [STAT_W-1:0] doneMask;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign regHit[g] = (busAddr == ADDR_W'(REG_OFS[g]));
  end

  // completion mask: data flag always, interrupt classes by enable and command kind
  always_comb begin
    doneMask               = '0;
    doneMask[ST_DATA_FLAG] = 1'b1;
    doneMask[ST_DATA_IRQ]  = cfgQ[CF_DATA_EN];
    doneMask[ST_BUSY_IRQ]  = cmdBusyWait & cfgQ[CF_BUSY_EN];
    doneMask[ST_BLOCK_IRQ] = cmdIsWrite & cfgQ[CF_BLOCK_EN];
  end

  always_comb begin
    strb.wrStat    = busWrEn & regHit[0];
    strb.wrCfg     = busWrEn & regHit[1];
    strb.wrDbg     = busWrEn & regHit[2];
    strb.enterData = xferDone;
    strb.setMask   = evtSet | (xferDone ? doneMask : '0);
    unique case (1'b1)
      regHit[0]: strb.rdSel = SEL_STAT;
      regHit[1]: strb.rdSel = SEL_CFG;
      regHit[2]: strb.rdSel = SEL_DBG;
      default:   strb.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sdh_stat_regs.sv
module sdh_stat_regs
  import sdh_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [STAT_W-1:0] statQ,
  output logic [CFG_W-1:0]  cfgQ,
  output logic [DBG_W-1:0]  dbgQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  logic [STAT_W-1:0] clrMask;
  logic [STAT_W-1:0] statNext;
  logic [DBG_W-1:0]  dbgNext;

  assign clrMask  = strb.wrStat ? busWrData[STAT_W-1:0] : '0;
  assign statNext = (statQ & ~clrMask) | strb.setMask;

  always_comb begin
    dbgNext = dbgQ;
    if (strb.wrDbg) begin
      dbgNext = busWrData[DBG_W-1:0];
      if (busWrData[STATE_W-1:0] == STATE_PWRDOWN) dbgNext[STATE_W-1:0] = STATE_IDLE;
    end
    if (strb.enterData) dbgNext[STATE_W-1:0] = STATE_DATA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      cfgQ  <= '0;
      dbgQ  <= DBG_RESET;
    end else begin
      statQ <= statNext;
      dbgQ  <= dbgNext;
      if (strb.wrCfg) cfgQ <= busWrData[CFG_W-1:0];
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_STAT: rdData = DATA_W'(statQ);
      SEL_CFG:  rdData = DATA_W'(cfgQ);
      SEL_DBG:  rdData = DATA_W'(dbgQ);
      default:  rdData = '0;
    endcase
  end

  assign irqOut = |statQ[ST_BUSY_IRQ:ST_DATA_IRQ];

endmodule

// File: rtl/sdh_status_irq.sv
module sdh_status_irq
  import sdh_stat_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [STAT_W-1:0] evtSet,
  input  logic              xferDone,
  input  logic              cmdBusyWait,
  input  logic              cmdIsWrite,
  output logic              irqOut
);

  strobes_t          strb;
  logic [STAT_W-1:0] statQ;
  logic [CFG_W-1:0]  cfgQ;
  logic [DBG_W-1:0]  dbgQ;

  sdh_stat_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .evtSet      (evtSet),
    .xferDone    (xferDone),
    .cmdBusyWait (cmdBusyWait),
    .cmdIsWrite  (cmdIsWrite),
    .cfgQ        (cfgQ),
    .strb        (strb)
  );

  sdh_stat_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWrData (busWrData),
    .statQ     (statQ),
    .cfgQ      (cfgQ),
    .dbgQ      (dbgQ),
    .rdData    (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/sdh_status_irq_chk.sv
module sdh_status_irq_chk
  import sdh_stat_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [STAT_W-1:0] evtSet,
  input logic              xferDone,
  input logic              cmdBusyWait,
  input logic              cmdIsWrite,
  input logic              irqOut,
  input logic [STAT_W-1:0] statQ,
  input logic [CFG_W-1:0]  cfgQ,
  input logic [DBG_W-1:0]  dbgQ
);

  // R2
  clear_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_STATUS) && evtSet == '0 && !xferDone)
    |=> ((statQ & $past(busWrData[STAT_W-1:0])) == '0));

  // R12
  set_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != '0) |=> ((statQ & $past(evtSet)) == $past(evtSet)));

  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(xferDone) || $past(evtSet[ST_BUSY_IRQ:ST_DATA_IRQ] != '0)));

  // R4
  done_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> statQ[ST_DATA_FLAG]);

  // R5
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && cmdBusyWait && cfgQ[CF_BUSY_EN]) |=> statQ[ST_BUSY_IRQ]);

  // R6
  block_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && cmdIsWrite && cfgQ[CF_BLOCK_EN]) |=> statQ[ST_BLOCK_IRQ]);

  // R7
  data_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> (dbgQ[STATE_W-1:0] == STATE_DATA));

  // R8
  pwrdown_absorb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(OFS_DEBUG) && busWrData[STATE_W-1:0] == STATE_PWRDOWN && !xferDone)
    |=> (dbgQ[STATE_W-1:0] == STATE_IDLE));

endmodule

bind sdh_status_irq sdh_status_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busWrData   (busWrData),
  .evtSet      (evtSet),
  .xferDone    (xferDone),
  .cmdBusyWait (cmdBusyWait),
  .cmdIsWrite  (cmdIsWrite),
  .irqOut      (irqOut),
  .statQ       (statQ),
  .cfgQ        (cfgQ),
  .dbgQ        (dbgQ)
);

// File: tb/sdh_status_irq_test.sv
module sdh_status_irq_test;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h04;
  localparam logic [ADDR_W-1:0] A_DBG  = 6'h08;

  // {config[10:0], busyWait, write, expected status[10:0]}
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    {11'h000, 1'b0, 1'b0, 11'h001},
    {11'h010, 1'b0, 1'b0, 11'h101},
    {11'h400, 1'b1, 1'b0, 11'h401},
    {11'h400, 1'b0, 1'b1, 11'h001},
    {11'h100, 1'b0, 1'b1, 11'h201},
    {11'h100, 1'b1, 1'b0, 11'h001},
    {11'h510, 1'b1, 1'b1, 11'h701},
    {11'h500, 1'b0, 1'b0, 11'h001}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic [10:0]       evtSet = '0;
  logic              xferDone = 1'b0;
  logic              cmdBusyWait = 1'b0;
  logic              cmdIsWrite = 1'b0;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdh_status_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .evtSet(evtSet),
    .xferDone(xferDone), .cmdBusyWait(cmdBusyWait), .cmdIsWrite(cmdIsWrite),
    .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [ADDR_W-1:0] a, logic [31:0] d);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    tick();
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic regRead(logic [ADDR_W-1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) tick();
    rstN = 1'b1;

    // R1 reset state
    regRead(A_STAT, rd); check("R1 status", rd, 32'h0);
    regRead(A_CFG, rd);  check("R1 config", rd, 32'h0);
    regRead(A_DBG, rd);  check("R1 debug", rd, 32'h0000C60F);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R12 set strobes
    evtSet = 11'h0C0; tick(); evtSet = '0;
    regRead(A_STAT, rd); check("R12 set strobes", rd, 32'h0C0);
    check("R12 irq stays low", {31'b0, irqOut}, 32'h0);
    evtSet = 11'h7FF; tick(); evtSet = '0;
    regRead(A_STAT, rd); check("R12 all positions", rd, 32'h7FF);
    regWrite(A_STAT, 32'hFFFFFFFF);
    regRead(A_STAT, rd); check("R2 clear all", rd, 32'h0);
    evtSet = 11'h0C0; tick(); evtSet = '0;

    // R2 write-one-to-clear
    regWrite(A_STAT, 32'h040);
    regRead(A_STAT, rd); check("R2 partial clear", rd, 32'h080);

    // R10 set beats clear
    evtSet = 11'h040;
    regWrite(A_STAT, 32'h0C0);
    evtSet = '0;
    regRead(A_STAT, rd); check("R10 set wins", rd, 32'h040);

    // R3 interrupt follows status
    evtSet = 11'h100; tick(); evtSet = '0;
    check("R3 irq high", {31'b0, irqOut}, 32'h1);
    regWrite(A_STAT, 32'h100);
    check("R3 irq low after clear", {31'b0, irqOut}, 32'h0);
    regRead(A_STAT, rd); check("R3 status after clear", rd, 32'h040);

    // R13 configuration width
    regWrite(A_CFG, 32'hFFFFFFFF);
    regRead(A_CFG, rd); check("R13 config", rd, 32'h7FF);
    regWrite(A_CFG, 32'h0);

    // R8 / R9 debug word
    regWrite(A_DBG, 32'h00044E0F);
    regRead(A_DBG, rd); check("R8 power-down absorbed", rd, 32'h00044E00);
    check("R9 write threshold", (rd >> 9) & 32'h1F, 32'd7);
    check("R9 read threshold", (rd >> 14) & 32'h1F, 32'd17);
    regWrite(A_DBG, 32'hFFFFFFF3);
    regRead(A_DBG, rd); check("R9 upper bits zero, R8 state kept", rd, 32'h003FFFF3);

    // R7 completion moves state to data mode
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    regRead(A_DBG, rd); check("R7 state to data", rd, 32'h003FFFF1);
    regRead(A_STAT, rd); check("R4 data flag", rd, 32'h041);

    // R7 completion against debug write in the same cycle
    xferDone = 1'b1;
    regWrite(A_DBG, 32'h0000000F);
    xferDone = 1'b0;
    regRead(A_DBG, rd); check("R7 completion over write", rd, 32'h00000001);

    // R11 unmapped offsets
    regWrite(6'h10, 32'hFFFFFFFF);
    regWrite(6'h0C, 32'hFFFFFFFF);
    regRead(6'h10, rd); check("R11 read zero 0x10", rd, 32'h0);
    regRead(6'h0C, rd); check("R11 read zero 0x0C", rd, 32'h0);
    regRead(A_STAT, rd); check("R11 status untouched", rd, 32'h041);
    regRead(A_CFG, rd);  check("R11 config untouched", rd, 32'h0);
    regRead(A_DBG, rd);  check("R11 debug untouched", rd, 32'h00000001);

    // R4 R5 R6 R3 completion gating table
    for (int i = 0; i < NVEC; i++) begin
      logic [10:0] cfgV;
      logic [10:0] expV;
      cfgV = VEC[i][23:13];
      expV = VEC[i][10:0];
      regWrite(A_STAT, 32'h7FF);
      regWrite(A_CFG, {21'b0, cfgV});
      cmdBusyWait = VEC[i][12];
      cmdIsWrite  = VEC[i][11];
      xferDone = 1'b1; tick(); xferDone = 1'b0;
      cmdBusyWait = 1'b0; cmdIsWrite = 1'b0;
      regRead(A_STAT, rd);
      check($sformatf("R4 R5 R6 vector %0d", i), rd, {21'b0, expV});
      check($sformatf("R3 irq vector %0d", i), {31'b0, irqOut}, {31'b0, |expV[10:8]});
    end

    // R10 completion against clear
    regWrite(A_STAT, 32'h7FF);
    regWrite(A_CFG, 32'h010);
    xferDone = 1'b1;
    regWrite(A_STAT, 32'h101);
    xferDone = 1'b0;
    regRead(A_STAT, rd); check("R10 completion beats clear", rd, 32'h101);
    check("R10 irq", {31'b0, irqOut}, 32'h1);

    finish();
  end

endmodule